// File: doc/BRIEF.md
# Channel Fault Retry and Latch Controller

This block is the per-channel sequencing core of a protected high-side output switch. A host asserts an on request and supplies configuration fields. These fields set the latch policy, the capacitive-charging mode, the inrush current limit code and the inrush duration code. The block then drives the switch enable and tells the analog front end which current threshold is active: an inrush shutdown level, an inrush current-regulation level, or the steady-state level.

Digitized overcurrent and thermal-shutdown inputs turn the channel off. After a shutdown the channel follows one of two paths. In the first it waits a fixed retry delay and starts again through the inrush period. In the second it stays latched off until a qualifying toggle releases it. The two toggles are an off-then-on sequence of the on request and a 1-then-0 sequence of the latch bit. A limp-home indication forces auto-retry for a channel configured to run in that state. The block reports a fault flag, the cause of the latest shutdown and its current state.

Top module: `chan_guard_ctrl`

## Requirements
- R1: While reset is active and in the first cycle after it, state_o is 0 (OFF), sw_en is 0, fault_flag is 0, fault_kind is 0 and thr_sel is 0. The state codes are OFF=0, INRUSH=1, STEADY=2, RETRY=3 and LATCHED=4.
- R2: With on_req high in OFF, a nonzero inrush_dur code c starts INRUSH. INRUSH lasts INRUSH_BASE<<(c-1) cycles and is followed by STEADY. Code 0 goes straight to STEADY. sw_en is high exactly in INRUSH and STEADY.
- R3: In INRUSH, thr_sel is 2'b10 (regulation) when chg_mode is 2'b10 and 2'b01 (shutdown level) for any other mode, and thr_lvl equals inrush_lim. Outside INRUSH, thr_sel is 2'b00 (steady level) and thr_lvl is 0.
- R4: In INRUSH or STEADY, th_trip, or oc_trip where it applies (see R9), drives sw_en low on the next cycle and sets fault_flag.
- R5: After a shutdown with latch_cfg at 0, the channel sits in RETRY for RETRY_CYC cycles. It then restarts as in R2, into INRUSH, or into STEADY when the duration code is 0.
- R6: After a shutdown with latch_cfg at 1 and no limp-home retry, the channel enters LATCHED and holds sw_en low until it is released.
- R7: A LATCHED channel is released by latch_cfg going from 1 to 0 while on_req is high, or by on_req going low and then high again. After release it restarts as in R2.
- R8: When limp_mode and limp_on are both high, a shutdown always leads to RETRY, whatever latch_cfg is.
- R9: In INRUSH with chg_mode 2'b10, oc_trip has no effect. Only th_trip shuts the channel down there.
- R10: on_req low moves the channel to OFF on the next cycle from any state. A running retry delay is cancelled and the channel stays OFF.
- R11: fault_kind holds the cause of the latest shutdown: 2'b10 thermal, 2'b01 overcurrent. Thermal wins when both inputs are high in the same cycle. fault_flag clears on entry to STEADY or on leaving LATCHED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_req | input | 1 | Channel on request |
| latch_cfg | input | 1 | 1 = latch off after a fault, 0 = auto-retry |
| chg_mode | input | 2 | Capacitive-charging mode, 2'b10 = regulated inrush |
| inrush_lim | input | LIM_W | Inrush current level code |
| inrush_dur | input | DUR_W | Inrush duration code, 0 = no inrush |
| limp_mode | input | 1 | Limp-home state is active |
| limp_on | input | 1 | Channel is configured on for limp-home |
| oc_trip | input | 1 | Overcurrent comparator trip |
| th_trip | input | 1 | Thermal shutdown trip |
| sw_en | output | 1 | Switch enable |
| thr_sel | output | 2 | Active threshold: 00 steady, 01 inrush shutdown, 10 inrush regulation |
| thr_lvl | output | LIM_W | Inrush level code forwarded during INRUSH, else 0 |
| fault_flag | output | 1 | Shutdown has occurred and is not yet cleared |
| fault_kind | output | 2 | Cause of the latest shutdown |
| state_o | output | 3 | Current state code |

## Verification
The properties assume that every input is synchronous to clk and holds still across the rising edge. They also assume that the trip inputs are already qualified, clean levels, so a one-cycle pulse is a real fault. The stimulus changes every input only on the falling edge. Faults are kept rare in the random phase, and the duration codes stay small so that the channel reaches every state often. Directed runs cover the retry and latch counts, both release toggles, limp-home override, regulated inrush and simultaneous fault causes.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_INRUSH  = 3'd1,
        ST_STEADY  = 3'd2,
        ST_RETRY   = 3'd3,
        ST_LATCHED = 3'd4
    } cg_state_e;

    localparam logic [1:0] MODE_REG   = 2'b10;

    localparam logic [1:0] THR_STEADY = 2'b00;
    localparam logic [1:0] THR_SHUT   = 2'b01;
    localparam logic [1:0] THR_REG    = 2'b10;

    localparam logic [1:0] KIND_NONE  = 2'b00;
    localparam logic [1:0] KIND_OC    = 2'b01;
    localparam logic [1:0] KIND_TH    = 2'b10;

endpackage

// File: rtl/chan_guard_edge.sv
module chan_guard_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic fall
);

    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign fall = prev_q & ~sig;

endmodule

// File: rtl/chan_guard_durlut.sv
module chan_guard_durlut #(
    parameter int CODE_W = 3,
    parameter int BASE   = 4,
    parameter int CNT_W  = 9
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  cycles,
    output logic              zero
);

    localparam int N_ENT = 1 << CODE_W;

    logic [CNT_W-1:0] tbl [N_ENT];

    generate
        for (genvar i = 0; i < N_ENT; i++) begin : g_ent
            if (i == 0) begin : g_none
                assign tbl[i] = '0;
            end else begin : g_len
                assign tbl[i] = CNT_W'(BASE << (i - 1));
            end
        end
    endgenerate

    assign cycles = tbl[code];
    assign zero   = (code == '0);

endmodule

// File: rtl/chan_guard_ctrl.sv
module chan_guard_ctrl
    import chan_guard_pkg::*;
#(
    parameter int INRUSH_BASE = 4,
    parameter int RETRY_CYC   = 24,
    parameter int LIM_W       = 4,
    parameter int DUR_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             on_req,
    input  logic             latch_cfg,
    input  logic [1:0]       chg_mode,
    input  logic [LIM_W-1:0] inrush_lim,
    input  logic [DUR_W-1:0] inrush_dur,
    input  logic             limp_mode,
    input  logic             limp_on,
    input  logic             oc_trip,
    input  logic             th_trip,
    output logic             sw_en,
    output logic [1:0]       thr_sel,
    output logic [LIM_W-1:0] thr_lvl,
    output logic             fault_flag,
    output logic [1:0]       fault_kind,
    output logic [2:0]       state_o
);

    localparam int MAX_INRUSH = INRUSH_BASE << ((1 << DUR_W) - 2);
    localparam int CNT_MAX    = (MAX_INRUSH > RETRY_CYC) ? MAX_INRUSH : RETRY_CYC;
    localparam int CNT_W      = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] RETRY_LOAD = CNT_W'(RETRY_CYC - 1);

    typedef struct packed {
        cg_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic             flag;
        logic [1:0]       kind;
    } regs_t;

    regs_t q, d;

    logic [CNT_W-1:0] dur_cyc;
    logic             dur_zero;
    logic             latch_fall;

    chan_guard_durlut #(
        .CODE_W (DUR_W),
        .BASE   (INRUSH_BASE),
        .CNT_W  (CNT_W)
    ) u_lut (
        .code   (inrush_dur),
        .cycles (dur_cyc),
        .zero   (dur_zero)
    );

    chan_guard_edge u_latch_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (latch_cfg),
        .fall  (latch_fall)
    );

    logic      fault_hit;
    logic      retry_go;
    cg_state_e start_st;
    logic [CNT_W-1:0] start_cnt;

    always_comb begin
        fault_hit = th_trip |
                    (oc_trip & ~((q.st == ST_INRUSH) && (chg_mode == MODE_REG)));
        retry_go  = (limp_mode & limp_on) | ~latch_cfg;
        start_st  = dur_zero ? ST_STEADY : ST_INRUSH;
        start_cnt = dur_zero ? '0 : (dur_cyc - CNT_W'(1));
    end

    always_comb begin
        d = q;
        if (!on_req) begin
            d.st  = ST_OFF;
            d.cnt = '0;
            if (q.st == ST_LATCHED) d.flag = 1'b0;
        end else begin
            unique case (q.st)
                ST_OFF: begin
                    d.st  = start_st;
                    d.cnt = start_cnt;
                    if (dur_zero) d.flag = 1'b0;
                end
                ST_INRUSH, ST_STEADY: begin
                    if (fault_hit) begin
                        d.flag = 1'b1;
                        d.kind = th_trip ? KIND_TH : KIND_OC;
                        if (retry_go) begin
                            d.st  = ST_RETRY;
                            d.cnt = RETRY_LOAD;
                        end else begin
                            d.st  = ST_LATCHED;
                            d.cnt = '0;
                        end
                    end else if (q.st == ST_INRUSH) begin
                        if (q.cnt == '0) begin
                            d.st   = ST_STEADY;
                            d.flag = 1'b0;
                        end else begin
                            d.cnt = q.cnt - CNT_W'(1);
                        end
                    end
                end
                ST_RETRY: begin
                    if (q.cnt == '0) begin
                        d.st  = start_st;
                        d.cnt = start_cnt;
                        if (dur_zero) d.flag = 1'b0;
                    end else begin
                        d.cnt = q.cnt - CNT_W'(1);
                    end
                end
                ST_LATCHED: begin
                    if (latch_fall) begin
                        d.st   = start_st;
                        d.cnt  = start_cnt;
                        d.flag = 1'b0;
                    end
                end
                default: begin
                    d.st  = ST_OFF;
                    d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_OFF;
            q.cnt  <= '0;
            q.flag <= 1'b0;
            q.kind <= KIND_NONE;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        sw_en      = (q.st == ST_INRUSH) || (q.st == ST_STEADY);
        thr_sel    = THR_STEADY;
        thr_lvl    = '0;
        if (q.st == ST_INRUSH) begin
            thr_sel = (chg_mode == MODE_REG) ? THR_REG : THR_SHUT;
            thr_lvl = inrush_lim;
        end
        fault_flag = q.flag;
        fault_kind = q.kind;
        state_o    = q.st;
    end

endmodule

// File: rtl/chan_guard_chk.sv
module chan_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       on_req,
    input logic       latch_cfg,
    input logic [1:0] chg_mode,
    input logic       limp_mode,
    input logic       limp_on,
    input logic       oc_trip,
    input logic       th_trip,
    input logic       sw_en,
    input logic [1:0] thr_sel,
    input logic       fault_flag,
    input logic [1:0] fault_kind,
    input logic [2:0] state_o
);

    a_r10_off_next: assert property (@(posedge clk) disable iff (!rst_n)
        !on_req |=> (state_o == 3'd0) && !sw_en);

    a_r4_thermal_off: assert property (@(posedge clk) disable iff (!rst_n)
        on_req && ((state_o == 3'd1) || (state_o == 3'd2)) && th_trip
        |=> !sw_en && fault_flag && (fault_kind == 2'b10));

    a_r6_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
        on_req && (state_o == 3'd4) && !($past(latch_cfg) && !latch_cfg)
        |=> (state_o == 3'd4) && !sw_en);

    a_r8_limp_retry: assert property (@(posedge clk) disable iff (!rst_n)
        on_req && limp_mode && limp_on && (state_o == 3'd2) && oc_trip
        |=> state_o == 3'd3);

    a_r9_reg_no_trip: assert property (@(posedge clk) disable iff (!rst_n)
        on_req && (state_o == 3'd1) && (chg_mode == 2'b10) && !th_trip
        |=> sw_en);

    a_r3_idle_steady_thr: assert property (@(posedge clk) disable iff (!rst_n)
        !sw_en |-> thr_sel == 2'b00);

    a_r11_kind_known: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> fault_kind != 2'b00);

endmodule

bind chan_guard_ctrl chan_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_req     (on_req),
    .latch_cfg  (latch_cfg),
    .chg_mode   (chg_mode),
    .limp_mode  (limp_mode),
    .limp_on    (limp_on),
    .oc_trip    (oc_trip),
    .th_trip    (th_trip),
    .sw_en      (sw_en),
    .thr_sel    (thr_sel),
    .fault_flag (fault_flag),
    .fault_kind (fault_kind),
    .state_o    (state_o)
);

// File: tb/tb_chan_guard_ctrl.sv
module tb_chan_guard_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int BASE       = 4;
    localparam int RETRY      = 24;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       on_req = 1'b0;
    logic       latch_cfg = 1'b0;
    logic [1:0] chg_mode = 2'b00;
    logic [3:0] inrush_lim = 4'h5;
    logic [2:0] inrush_dur = 3'd0;
    logic       limp_mode = 1'b0;
    logic       limp_on = 1'b0;
    logic       oc_trip = 1'b0;
    logic       th_trip = 1'b0;
    logic       sw_en;
    logic [1:0] thr_sel;
    logic [3:0] thr_lvl;
    logic       fault_flag;
    logic [1:0] fault_kind;
    logic [2:0] state_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_guard_ctrl #(.INRUSH_BASE(BASE), .RETRY_CYC(RETRY)) dut (
        .clk(clk), .rst_n(rst_n), .on_req(on_req), .latch_cfg(latch_cfg),
        .chg_mode(chg_mode), .inrush_lim(inrush_lim), .inrush_dur(inrush_dur),
        .limp_mode(limp_mode), .limp_on(limp_on), .oc_trip(oc_trip),
        .th_trip(th_trip), .sw_en(sw_en), .thr_sel(thr_sel), .thr_lvl(thr_lvl),
        .fault_flag(fault_flag), .fault_kind(fault_kind), .state_o(state_o)
    );

    // reference model built from the requirements
    int m_st = 0, m_cnt = 0, m_flag = 0, m_kind = 0, m_latprev = 0;

    function automatic int exp_dur(input int code);
        return (code == 0) ? 0 : (BASE << (code - 1));
    endfunction

    function automatic int exp_thr(input int st, input int mode);
        if (st != 1) return 0;
        return (mode == 2) ? 2 : 1;
    endfunction

    task automatic m_start();
        if (exp_dur(int'(inrush_dur)) == 0) begin
            m_st = 2; m_flag = 0;
        end else begin
            m_st = 1; m_cnt = exp_dur(int'(inrush_dur));
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_flag = 0; m_kind = 0; m_latprev = 0;
        end else begin
            bit hit;
            hit = th_trip || (oc_trip && !(m_st == 1 && chg_mode == 2'b10));
            if (!on_req) begin
                if (m_st == 4) m_flag = 0;
                m_st = 0;
            end else begin
                case (m_st)
                    0: m_start();
                    1, 2: begin
                        if (hit) begin
                            m_flag = 1;
                            m_kind = th_trip ? 2 : 1;
                            if ((limp_mode && limp_on) || !latch_cfg) begin
                                m_st = 3; m_cnt = RETRY;
                            end else m_st = 4;
                        end else if (m_st == 1) begin
                            if (m_cnt == 1) begin m_st = 2; m_flag = 0; end
                            else m_cnt--;
                        end
                    end
                    3: begin
                        if (m_cnt == 1) m_start();
                        else m_cnt--;
                    end
                    4: begin
                        if (m_latprev == 1 && !latch_cfg) begin
                            m_flag = 0; m_start();
                        end
                    end
                    default: m_st = 0;
                endcase
            end
            m_latprev = int'(latch_cfg);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        int es;
        es = m_st;
        chk(int'(state_o) == es, cur_tag, int'(state_o), es);
        chk(sw_en == (es == 1 || es == 2), "R2 sw_en", int'(sw_en), int'(es == 1 || es == 2));
        chk(int'(thr_sel) == exp_thr(es, int'(chg_mode)), "R3 thr_sel",
            int'(thr_sel), exp_thr(es, int'(chg_mode)));
        chk(int'(thr_lvl) == ((es == 1) ? int'(inrush_lim) : 0), "R3 thr_lvl",
            int'(thr_lvl), (es == 1) ? int'(inrush_lim) : 0);
        chk(int'(fault_flag) == m_flag && int'(fault_kind) == m_kind, "R11 flag/kind",
            int'({fault_flag, fault_kind}), m_flag * 4 + m_kind);
    endtask

    task automatic cyc(input int n);
        repeat (n) begin
            @(negedge clk);
            compare();
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1-chain hung actual=0 expected=1");
            summary();
            $finish;
        end
    end

    initial begin
        int n;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk(state_o == 3'd0 && !sw_en && !fault_flag && fault_kind == 2'b00 && thr_sel == 2'b00,
            "R1 in reset", int'(state_o), 0);
        rst_n = 1'b1;
        cyc(1);
        chk(state_o == 3'd0 && !sw_en && !fault_flag, "R1 after reset", int'(state_o), 0);

        // R2: inrush length for code 2
        cur_tag = "R2";
        inrush_dur = 3'd2; on_req = 1'b1;
        n = 0;
        for (int i = 0; i < 12; i++) begin
            cyc(1);
            if (state_o == 3'd1) n++;
        end
        chk(n == exp_dur(2), "R2 inrush length", n, exp_dur(2));
        chk(state_o == 3'd2, "R2 steady after inrush", int'(state_o), 2);

        // R2: code 0 goes straight to steady
        on_req = 1'b0; cyc(1);
        inrush_dur = 3'd0; on_req = 1'b1; cyc(1);
        chk(state_o == 3'd2, "R2 zero duration", int'(state_o), 2);

        // R4/R5: overcurrent with auto-retry
        cur_tag = "R5";
        inrush_dur = 3'd1; on_req = 1'b0; cyc(1);
        on_req = 1'b1; cyc(6);
        oc_trip = 1'b1; cyc(1); oc_trip = 1'b0;
        chk(state_o == 3'd3 && !sw_en, "R4 shutdown to retry", int'(state_o), 3);
        chk(fault_flag && fault_kind == 2'b01, "R11 oc kind", int'(fault_kind), 1);
        n = 1;
        while (state_o == 3'd3 && n < 100) begin cyc(1); if (state_o == 3'd3) n++; end
        chk(n == RETRY, "R5 retry length", n, RETRY);
        chk(state_o == 3'd1, "R5 restart inrush", int'(state_o), 1);

        // R6/R7: latch and release by latch bit
        cur_tag = "R6";
        cyc(6);
        latch_cfg = 1'b1; th_trip = 1'b1; cyc(1); th_trip = 1'b0;
        chk(state_o == 3'd4 && fault_kind == 2'b10, "R6 latched", int'(state_o), 4);
        cyc(40);
        chk(state_o == 3'd4 && !sw_en, "R6 latch holds", int'(state_o), 4);
        cur_tag = "R7";
        latch_cfg = 1'b0; cyc(1);
        chk(state_o == 3'd1 && !fault_flag, "R7 latch bit release", int'(state_o), 1);

        // R7/R10: release by on toggle
        cyc(6);
        latch_cfg = 1'b1; cyc(1);
        oc_trip = 1'b1; cyc(1); oc_trip = 1'b0;
        chk(state_o == 3'd4, "R6 latched by oc", int'(state_o), 4);
        on_req = 1'b0; cyc(1);
        chk(state_o == 3'd0 && !fault_flag, "R10 off from latched", int'(state_o), 0);
        on_req = 1'b1; cyc(1);
        chk(state_o == 3'd1, "R7 on toggle release", int'(state_o), 1);

        // R8: limp-home overrides the latch bit
        cur_tag = "R8";
        cyc(6);
        limp_mode = 1'b1; limp_on = 1'b1;
        oc_trip = 1'b1; cyc(1); oc_trip = 1'b0;
        chk(state_o == 3'd3, "R8 limp retry", int'(state_o), 3);
        limp_mode = 1'b0; limp_on = 1'b0;
        cyc(RETRY);
        chk(state_o == 3'd1, "R8 limp restart", int'(state_o), 1);

        // R9/R3: regulated inrush ignores overcurrent
        cur_tag = "R9";
        latch_cfg = 1'b0; on_req = 1'b0; cyc(1);
        inrush_dur = 3'd3; chg_mode = 2'b10; on_req = 1'b1; cyc(1);
        chk(thr_sel == 2'b10 && thr_lvl == 4'h5, "R3 regulation select", int'(thr_sel), 2);
        oc_trip = 1'b1; cyc(5);
        chk(state_o == 3'd1 && sw_en, "R9 oc ignored", int'(state_o), 1);
        oc_trip = 1'b0; cyc(15);
        chk(state_o == 3'd2 && thr_sel == 2'b00, "R3 steady select", int'(thr_sel), 0);
        chg_mode = 2'b00; inrush_lim = 4'hB; on_req = 1'b0; cyc(1);
        on_req = 1'b1; cyc(1);
        chk(thr_sel == 2'b01 && thr_lvl == 4'hB, "R3 shutdown select", int'(thr_sel), 1);
        oc_trip = 1'b1; cyc(1); oc_trip = 1'b0;
        chk(state_o == 3'd3, "R4 inrush shutdown", int'(state_o), 3);

        // R10: off cancels the retry
        cur_tag = "R10";
        cyc(2);
        on_req = 1'b0; cyc(1);
        chk(state_o == 3'd0, "R10 retry cancelled", int'(state_o), 0);
        cyc(RETRY + 5);
        chk(state_o == 3'd0 && !sw_en, "R10 stays off", int'(state_o), 0);

        // R11: thermal priority, flag clears on steady
        cur_tag = "R11";
        inrush_dur = 3'd0; on_req = 1'b1; cyc(1);
        oc_trip = 1'b1; th_trip = 1'b1; cyc(1); oc_trip = 1'b0; th_trip = 1'b0;
        chk(fault_kind == 2'b10 && fault_flag, "R11 thermal wins", int'(fault_kind), 2);
        cyc(RETRY);
        chk(state_o == 3'd2 && !fault_flag, "R11 flag cleared", int'(fault_flag), 0);

        // random phase
        cur_tag = "R4 random";
        for (int i = 0; i < 4000; i++) begin
            on_req     = ($urandom % 40) != 0;
            if (($urandom % 25) == 0) latch_cfg = ~latch_cfg;
            if (($urandom % 50) == 0) chg_mode = 2'($urandom);
            inrush_lim = 4'($urandom);
            if (($urandom % 30) == 0) inrush_dur = 3'($urandom % 4);
            if (($urandom % 60) == 0) limp_mode = ~limp_mode;
            limp_on    = ($urandom % 2) == 0;
            oc_trip    = ($urandom % 20) == 0;
            th_trip    = ($urandom % 45) == 0;
            cyc(1);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule